// File: doc/BRIEF.md
# Run/Wait/Stop Internal Clock Controller

This block decides whether the internal processor clock of a small controller runs, parks, or is shut down together with the oscillator. It runs on the raw oscillator clock and makes the internal clock `phi` by dividing that clock by two. In run mode `phi` toggles freely. A wait request parks `phi` at logic high but leaves the oscillator enabled. A stop request parks `phi` high and also drops the oscillator enable.

Waking from wait happens on the same edge that an accepted interrupt is seen. Only the sources that keep running during wait can wake the block, and these are picked by a parameter mask. Waking from stop needs an accepted external interrupt. The oscillator enable then rises at once, but `phi` stays parked until a settling delay has passed. That delay comes from two cascaded 8-bit down counters, which are loaded with 0xFF and 0x07 on stop entry. The first counter counts the oscillator divided by 16, so the delay is 32768 oscillator cycles.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `rst` is high, at each edge `status` becomes 2'b00 (run), `osc_en` becomes 1 and `phi` becomes 1.
- R2: In run mode `phi` inverts on every oscillator edge, so its period is two oscillator cycles.
- R3: A `wait_req` pulse in run mode gives `status` = 2'b01 (wait), `phi` = 1 and `osc_en` = 1 from that edge onward, until a wake.
- R4: A `stop_req` pulse in run mode gives `status` = 2'b10 (stop), `osc_en` = 0 and `phi` = 1 from that edge onward. When both requests arrive on the same edge, stop wins.
- R5: In wait mode, an edge with `irq_dis` = 0 and either `ext_irq` = 1 or some `irq_src[i]` = 1 where `WAKE_MASK[i]` = 1 moves the block to run on that edge. On that edge `phi` falls to 0.
- R6: In wait mode, `irq_src` bits whose `WAKE_MASK` bit is 0 are ignored, and every interrupt is ignored while `irq_dis` = 1. The block stays in wait with `phi` = 1.
- R7: In stop mode, only `ext_irq` = 1 with `irq_dis` = 0 is accepted. On that edge `status` becomes 2'b11 (settling) and `osc_en` becomes 1. `irq_src` and a disabled `ext_irq` leave the block in stop.
- R8: Settling lasts exactly (LOAD_A+1)*(LOAD_B+1)*2^PRE_W = 32768 oscillator edges with `phi` held at 1. On the next edge `status` returns to 2'b00 and `phi` falls.
- R9: `stop_req` and `wait_req` are ignored outside run mode, and `ext_irq` is ignored while settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-mode request pulse |
| wait_req | input | 1 | Wait-mode request pulse |
| ext_irq | input | 1 | External interrupt; the only source that can end stop |
| irq_src | input | N_SRC | Internal interrupt requests, screened by WAKE_MASK in wait |
| irq_dis | input | 1 | Interrupt-disable flag; 1 blocks all wakes |
| osc_en | output | 1 | Oscillator enable |
| phi | output | 1 | Gated internal clock, parked high |
| status | output | 2 | 00 run, 01 wait, 10 stop, 11 settling |

## Verification
A mode register in the wrong state shows at once on `status` and `phi`: a wrong wait or stop decision parks `phi` high, or fails to park it, on the very edge of the event. A fault in the settling cascade, such as a wrong load value, a wrong prescale tap or a missed borrow, only shows at the end of settling. There the return to run comes early or late by a whole prescale or counter period, so the bench counts every edge of both stop wakes and checks the exit edge.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10,
        MODE_STAB = 2'b11
    } mode_e;

    typedef struct packed {
        logic enter_stop;
        logic enter_idle;
        logic stop_wake;
        logic idle_wake;
    } evt_t;

    function automatic int unsigned stab_cycles(int unsigned pre_w,
                                                int unsigned load_a,
                                                int unsigned load_b);
        return (load_a + 1) * (load_b + 1) * (32'd1 << pre_w);
    endfunction

endpackage

// File: rtl/cmc_prescale.sv
module cmc_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic clear,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (clear) pre_q <= '0;
        else       pre_q <= pre_q + 1'b1;
    end

    assign tick = !clear && (&pre_q);
endmodule

// File: rtl/cmc_stab_chain.sv
module cmc_stab_chain #(
    parameter int TW     = 8,
    parameter int LOAD_A = 255,
    parameter int LOAD_B = 7
) (
    input  logic clk,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int N_STG = 2;

    logic [N_STG:0] borrow;
    assign borrow[0] = tick;

    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        localparam logic [TW-1:0] LD = (g == 0) ? TW'(LOAD_A) : TW'(LOAD_B);
        logic [TW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (load)
                cnt_q <= LD;
            else if (borrow[g])
                cnt_q <= (cnt_q == '0) ? LD : cnt_q - 1'b1;
        end

        assign borrow[g+1] = borrow[g] && (cnt_q == '0);
    end

    assign done = borrow[N_STG];
endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import cmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  ev,
    input  logic  stab_done,
    output mode_e mode_q,
    output mode_e mode_d
);
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (ev.enter_stop)      mode_d = MODE_STOP;
                else if (ev.enter_idle) mode_d = MODE_WAIT;
            end
            MODE_WAIT: if (ev.idle_wake) mode_d = MODE_RUN;
            MODE_STOP: if (ev.stop_wake) mode_d = MODE_STAB;
            MODE_STAB: if (stab_done)    mode_d = MODE_RUN;
            default:   mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= mode_d;
    end

    // R4 R7: stop exits only into settling
    a_r7_stop_exit: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_STOP |=> (mode_q == MODE_STOP || mode_q == MODE_STAB));

    // R9: settling never returns to stop or wait
    a_r9_stab_exit: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_STAB |=> (mode_q == MODE_STAB || mode_q == MODE_RUN));
endmodule

// File: rtl/cmc_phi_gate.sv
module cmc_phi_gate (
    input  logic clk,
    input  logic rst,
    input  logic open_d,
    output logic phi
);
    always_ff @(posedge clk) begin
        if (rst)         phi <= 1'b1;
        else if (open_d) phi <= ~phi;
        else             phi <= 1'b1;
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] WAKE_MASK = 8'b0011_0101,
    parameter int               TW        = 8,
    parameter int               LOAD_A    = 255,
    parameter int               LOAD_B    = 7,
    parameter int               PRE_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic             ext_irq,
    input  logic [N_SRC-1:0] irq_src,
    input  logic             irq_dis,
    output logic             osc_en,
    output logic             phi,
    output logic [1:0]       status
);
    localparam int unsigned DELAY = stab_cycles(PRE_W, LOAD_A, LOAD_B);

    evt_t  ev;
    mode_e mode_q, mode_d;
    logic  in_stab, tick, stab_done;

    always_comb begin
        ev.enter_stop = stop_req;
        ev.enter_idle = wait_req;
        ev.stop_wake  = ext_irq && !irq_dis;
        ev.idle_wake  = (ext_irq || (|(irq_src & WAKE_MASK))) && !irq_dis;
    end

    assign in_stab = (mode_q == MODE_STAB);

    cmc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .clear (rst || !in_stab),
        .tick  (tick)
    );

    cmc_stab_chain #(.TW(TW), .LOAD_A(LOAD_A), .LOAD_B(LOAD_B)) u_chain (
        .clk  (clk),
        .load (rst || !in_stab),
        .tick (tick),
        .done (stab_done)
    );

    cmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .stab_done (stab_done),
        .mode_q    (mode_q),
        .mode_d    (mode_d)
    );

    cmc_phi_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .open_d (mode_d == MODE_RUN),
        .phi    (phi)
    );

    assign osc_en = (mode_q != MODE_STOP);
    assign status = mode_q;

    // settling-length monitor for R8
    int unsigned stab_len;
    always_ff @(posedge clk) begin
        if (rst || !in_stab) stab_len <= 0;
        else                 stab_len <= stab_len + 1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (status == 2'b00 && osc_en && phi));

    a_r2_phi_toggles: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && !$past(rst)) |-> phi != $past(phi));

    a_r3_phi_parked: assert property (@(posedge clk) disable iff (rst)
        mode_q != MODE_RUN |-> phi);

    a_r4_osc_off_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> $past(stop_req));

    a_r6_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WAIT && (irq_dis || !(ext_irq || (|(irq_src & WAKE_MASK)))))
        |=> mode_q == MODE_WAIT);

    a_r7_stop_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STOP && !(ext_irq && !irq_dis)) |=> mode_q == MODE_STOP);

    a_r8_stab_length: assert property (@(posedge clk) disable iff (rst)
        (in_stab && mode_d == MODE_RUN) |-> stab_len == DELAY - 1);
endmodule

// File: tb/test_clk_mode_ctrl.sv
`timescale 1ns/100ps
module test_clk_mode_ctrl;
    localparam logic [7:0] MASK  = 8'b0011_0101;
    localparam int         DELAY = (255 + 1) * (7 + 1) * 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 1'b0, wait_req = 1'b0, ext_irq = 1'b0, irq_dis = 1'b0;
    logic [7:0] irq_src = '0;
    logic       osc_en, phi;
    logic [1:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clk_mode_ctrl #(.N_SRC(8), .WAKE_MASK(MASK)) i_clk_mode_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
        .ext_irq(ext_irq), .irq_src(irq_src), .irq_dis(irq_dis),
        .osc_en(osc_en), .phi(phi), .status(status)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(string req, logic [1:0] st, logic osc, logic ph);
        chk(req, {30'd0, status}, {30'd0, st});
        chk(req, {31'd0, osc_en}, {31'd0, osc});
        chk(req, {31'd0, phi}, {31'd0, ph});
    endtask

    task automatic settle_and_check(string tag);
        bit bad = 1'b0;
        // edge e0 already taken: now settling
        chk_state({"R7 wake ", tag}, 2'b11, 1'b1, 1'b1);
        for (int i = 1; i < DELAY; i++) begin
            if (i == 100) begin stop_req = 1'b1; ext_irq = 1'b1; wait_req = 1'b1; end
            if (i == 101) begin stop_req = 1'b0; ext_irq = 1'b0; wait_req = 1'b0; end
            tick();
            if (status !== 2'b11 || phi !== 1'b1 || osc_en !== 1'b1) bad = 1'b1;
        end
        chk({"R8 R9 held through settling ", tag}, {31'd0, bad}, 32'd0);
        tick();
        chk_state({"R8 exit to run ", tag}, 2'b00, 1'b1, 1'b0);
        tick();
        chk({"R2 after settle ", tag}, {31'd0, phi}, 32'd1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic prev;
        // R1 reset
        tick(); tick(); tick();
        chk_state("R1 reset", 2'b00, 1'b1, 1'b1);
        rst = 1'b0;
        tick();
        chk("R2 first toggle", {31'd0, phi}, 32'd0);
        for (int i = 0; i < 10; i++) begin
            prev = phi;
            tick();
            chk("R2 toggle", {31'd0, phi}, {31'd0, ~prev});
        end

        // wait-mode sweep over every source and the disable flag
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                wait_req = 1'b1;
                tick();
                wait_req = 1'b0;
                chk_state("R3 wait entry", 2'b01, 1'b1, 1'b1);
                stop_req = 1'b1;
                tick();
                stop_req = 1'b0;
                chk_state("R9 stop ignored in wait", 2'b01, 1'b1, 1'b1);
                irq_src = 8'(1 << s);
                irq_dis = d[0];
                tick();
                irq_src = '0;
                irq_dis = 1'b0;
                if (MASK[s] && d == 0) begin
                    chk_state("R5 wait wake", 2'b00, 1'b1, 1'b0);
                end else begin
                    chk_state("R6 wait ignore", 2'b01, 1'b1, 1'b1);
                    ext_irq = 1'b1;
                    tick();
                    ext_irq = 1'b0;
                    chk_state("R5 ext wake from wait", 2'b00, 1'b1, 1'b0);
                end
                tick();
                chk("R2 resume", {31'd0, phi}, 32'd1);
            end
        end

        // stop with both requests, ignored events, then delayed wake
        stop_req = 1'b1; wait_req = 1'b1;
        tick();
        stop_req = 1'b0; wait_req = 1'b0;
        chk_state("R4 stop entry priority", 2'b10, 1'b0, 1'b1);
        irq_src = 8'hFF;
        tick();
        irq_src = '0;
        chk_state("R7 irq_src ignored in stop", 2'b10, 1'b0, 1'b1);
        ext_irq = 1'b1; irq_dis = 1'b1;
        tick();
        ext_irq = 1'b0; irq_dis = 1'b0;
        chk_state("R7 disabled ext ignored", 2'b10, 1'b0, 1'b1);
        wait_req = 1'b1;
        tick();
        wait_req = 1'b0;
        chk_state("R9 wait ignored in stop", 2'b10, 1'b0, 1'b1);
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
        settle_and_check("first");

        // stop with wake on the very next edge
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        chk_state("R4 stop entry", 2'b10, 1'b0, 1'b1);
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
        settle_and_check("second");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule